// File: doc/BRIEF.md
# Speculative Fetch Bus Controller

This block sequences a processor's external bus cycles for instruction fetches, data reads and data writes. When the instruction sequencer asks for an instruction, the controller launches an external cycle at once and pulses an early cycle-start strobe. The on-chip instruction cache is searched in the same clock. The cache result arrives one clock later. On a hit the external cycle is dropped: the cycle-start pulse has already been seen, but the address strobe never asserts. On a miss the address strobe asserts on the next clock and stays up until the bus acknowledges.

Data accesses come from a separate request port, which wins over a prefetch when both are ready. The controller decodes a two-bit size code and the low two address bits into four byte-lane enables for a 32-bit port. Instruction reads always enable every lane. A programmable minimum idle gap is enforced between a negation of the cycle-start strobe and its next assertion. Prefetches are paced so that two fetch launches never fall on adjacent clocks. A data access may still start on the clock that follows an aborted fetch.

Top module: `spec_fetch_bus`

## Requirements
- R1: After reset the controller is idle: cyc_start_o, addr_strobe_o, fetch_done_o and data_done_o are low, and read_o is high.
- R2: In an idle clock with fetch_req_i high, no data request and the gap satisfied, cyc_start_o is high in that same clock. The cache result is sampled on cache_hit_i in the next clock.
- R3: When cache_hit_i is high in the clock after a fetch launch, addr_strobe_o stays low for that fetch and the controller returns to idle.
- R4: When cache_hit_i is low in the clock after a fetch launch, addr_strobe_o asserts on the following clock and holds until the clock in which bus_ack_i is high. fetch_done_o is high in that clock. A fetch drives addr_o with the fetch address, byte_en_o = 4'b1111 whatever its low address bits, and read_o = 1.
- R5: A data request starts with cyc_start_o in its launch clock and addr_strobe_o from the next clock. read_o is the inverse of data_we_i (1 = read, 0 = write). data_done_o is high in the clock where bus_ack_i is sampled.
- R6: When a data request and a fetch request are both ready in the same clock, the data access is launched first. The fetch starts after the data access finishes.
- R7: cyc_start_o is never high while addr_strobe_o is high.
- R8: Two fetch launches never occur on adjacent clocks. A data launch is allowed in the clock that reports a cache hit, which gives cycle-start strobes on two consecutive clocks.
- R9: Byte enables for a data access: byte_en_o[3] is the lane at byte offset 0 and byte_en_o[0] is the lane at offset 3. Size code 01 is one byte, 10 is two, 11 is three and 00 is four. Lanes are enabled from offset data_addr_i[1:0] up to the end of the operand or to offset 3, whichever comes first.
- R10: Once cyc_start_o has been low, it stays low for at least gap_cfg_i clocks before it asserts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gap_cfg_i | input | GW | Minimum number of low clocks between cycle-start pulses |
| fetch_req_i | input | 1 | Instruction fetch request from the sequencer |
| fetch_addr_i | input | AW | Fetch address |
| cache_hit_i | input | 1 | Cache lookup result, valid in the clock after a fetch launch |
| data_req_i | input | 1 | Data access request, held until data_done_o |
| data_we_i | input | 1 | 1 = write, 0 = read |
| data_size_i | input | 2 | Operand size code |
| data_addr_i | input | AW | Data address |
| bus_ack_i | input | 1 | Bus cycle termination |
| cyc_start_o | output | 1 | Early cycle-start strobe |
| addr_strobe_o | output | 1 | Address strobe of a real external cycle |
| read_o | output | 1 | 1 = read cycle, 0 = write cycle |
| addr_o | output | AW | Address of the current cycle |
| byte_en_o | output | LANES | Active byte lanes, bit 3 = offset 0 |
| fetch_done_o | output | 1 | Fetch bus cycle completed |
| data_done_o | output | 1 | Data bus cycle completed |

## Verification
The bench targets the clock that reports a cache hit. It checks that the aborted fetch never raises the address strobe, and that a data launch in that same clock does come through. A design that lets the aborted fetch reach the bus would show a stray strobe. A design that forbids any start right after a hit would lose the back-to-back pulse. The bench also presents a fetch and a data request together, to catch reversed priority. It runs the idle gap at exactly its limit, where an off-by-one counter would launch a clock early or a clock late. Byte-lane patterns at unaligned offsets and operands that cross the end of the port are scored against fixed expected masks. Fetches use unaligned addresses, so a design that decodes lanes for instruction reads would produce a partial mask.

// File: rtl/spec_fetch_pkg.sv
package spec_fetch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_BUS} seq_state_e;
  typedef enum logic {CYC_FETCH, CYC_DATA} cyc_kind_e;
endpackage

// File: rtl/spec_fetch_lanes.sv
module spec_fetch_lanes #(
  parameter int LANES = 4,
  localparam int OFFW = $clog2(LANES)
) (
  input  logic [OFFW-1:0]  off_i,
  input  logic [OFFW-1:0]  size_i,
  output logic [LANES-1:0] be_o
);
  int first, last;

  always_comb begin
    first = int'(off_i);
    // size code 0 means a full port-width operand
    last  = first + ((size_i == '0) ? LANES : int'(size_i));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[LANES-1-i] = (i >= first) && (i < last);
  end
endmodule

// File: rtl/spec_fetch_gap.sv
module spec_fetch_gap #(
  parameter int GW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] gap_i,
  input  logic          start_i,
  output logic          ok_o
);
  logic [GW-1:0] low_cnt_q;
  logic          start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '1;
      start_q   <= 1'b0;
    end else begin
      start_q <= start_i;
      if (start_i)              low_cnt_q <= '0;
      else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // an unbroken run of pulses is not a re-assertion
  assign ok_o = start_q || (low_cnt_q >= gap_i);
endmodule

// File: rtl/spec_fetch_seq.sv
module spec_fetch_seq
  import spec_fetch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fetch_req_i,
  input  logic      data_req_i,
  input  logic      cache_hit_i,
  input  logic      bus_ack_i,
  input  logic      gap_ok_i,
  output logic      launch_fetch_o,
  output logic      launch_data_o,
  output logic      in_probe_o,
  output logic      in_bus_o,
  output cyc_kind_e kind_o
);
  seq_state_e state_q, state_d;
  cyc_kind_e  kind_q;

  always_comb begin
    state_d        = state_q;
    launch_fetch_o = 1'b0;
    launch_data_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (gap_ok_i) begin
          if (data_req_i)       launch_data_o  = 1'b1;
          else if (fetch_req_i) launch_fetch_o = 1'b1;
        end
        if (launch_data_o)       state_d = ST_BUS;
        else if (launch_fetch_o) state_d = ST_PROBE;
      end
      ST_PROBE: begin
        if (cache_hit_i) begin
          // abort; only a data access may follow immediately
          if (data_req_i && gap_ok_i) begin
            launch_data_o = 1'b1;
            state_d       = ST_BUS;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          state_d = ST_BUS;
        end
      end
      ST_BUS:  if (bus_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= CYC_FETCH;
    end else begin
      state_q <= state_d;
      if (launch_data_o)       kind_q <= CYC_DATA;
      else if (launch_fetch_o) kind_q <= CYC_FETCH;
    end
  end

  assign in_probe_o = (state_q == ST_PROBE);
  assign in_bus_o   = (state_q == ST_BUS);
  assign kind_o     = kind_q;
endmodule

// File: rtl/spec_fetch_bus.sv
module spec_fetch_bus
  import spec_fetch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LANES = 4,
  parameter int GW    = 4,
  localparam int OFFW = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GW-1:0]    gap_cfg_i,
  input  logic             fetch_req_i,
  input  logic [AW-1:0]    fetch_addr_i,
  input  logic             cache_hit_i,
  input  logic             data_req_i,
  input  logic             data_we_i,
  input  logic [OFFW-1:0]  data_size_i,
  input  logic [AW-1:0]    data_addr_i,
  input  logic             bus_ack_i,
  output logic             cyc_start_o,
  output logic             addr_strobe_o,
  output logic             read_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] byte_en_o,
  output logic             fetch_done_o,
  output logic             data_done_o
);
  logic             gap_ok, fetch_launch, data_launch, in_probe, in_bus;
  cyc_kind_e        kind;
  logic [LANES-1:0] data_be;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] be_q;
  logic             read_q;

  spec_fetch_gap #(.GW(GW)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gap_i  (gap_cfg_i),
    .start_i(cyc_start_o),
    .ok_o   (gap_ok)
  );

  spec_fetch_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_req_i   (fetch_req_i),
    .data_req_i    (data_req_i),
    .cache_hit_i   (cache_hit_i),
    .bus_ack_i     (bus_ack_i),
    .gap_ok_i      (gap_ok),
    .launch_fetch_o(fetch_launch),
    .launch_data_o (data_launch),
    .in_probe_o    (in_probe),
    .in_bus_o      (in_bus),
    .kind_o        (kind)
  );

  spec_fetch_lanes #(.LANES(LANES)) u_lanes (
    .off_i (data_addr_i[OFFW-1:0]),
    .size_i(data_size_i),
    .be_o  (data_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      be_q   <= '0;
      read_q <= 1'b1;
    end else if (data_launch) begin
      addr_q <= data_addr_i;
      be_q   <= data_be;
      read_q <= ~data_we_i;
    end else if (fetch_launch) begin
      addr_q <= fetch_addr_i;
      be_q   <= '1;  // instruction reads use every lane
      read_q <= 1'b1;
    end
  end

  assign cyc_start_o   = fetch_launch | data_launch;
  assign addr_strobe_o = in_bus;
  assign read_o        = read_q;
  assign addr_o        = addr_q;
  assign byte_en_o     = be_q;
  assign fetch_done_o  = in_bus && bus_ack_i && (kind == CYC_FETCH);
  assign data_done_o   = in_bus && bus_ack_i && (kind == CYC_DATA);
endmodule

// File: rtl/spec_fetch_bus_chk.sv
module spec_fetch_bus_chk #(
  parameter int GW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [GW-1:0] gap_cfg_i,
  input logic          cache_hit_i,
  input logic          bus_ack_i,
  input logic          cyc_start_o,
  input logic          addr_strobe_o,
  input logic          fetch_done_o,
  input logic          data_done_o,
  input logic          in_probe,
  input logic          fetch_launch
);
  logic [GW-1:0] low_run;
  logic          start_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run    <= '1;
      start_prev <= 1'b0;
    end else begin
      start_prev <= cyc_start_o;
      if (cyc_start_o)        low_run <= '0;
      else if (low_run != '1) low_run <= low_run + 1'b1;
    end
  end

  AST_HIT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_probe && cache_hit_i && !cyc_start_o) |=> !addr_strobe_o); // R3
  AST_MISS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_probe && !cache_hit_i) |=> addr_strobe_o); // R4
  AST_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_strobe_o && !bus_ack_i) |=> addr_strobe_o); // R4
  AST_DONE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_o || data_done_o) |-> (addr_strobe_o && bus_ack_i)); // R5
  AST_START_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> !addr_strobe_o); // R7
  AST_FETCH_PACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_launch |=> !fetch_launch); // R8
  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && !start_prev) |-> (low_run >= gap_cfg_i)); // R10
endmodule

bind spec_fetch_bus spec_fetch_bus_chk #(.GW(GW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gap_cfg_i    (gap_cfg_i),
  .cache_hit_i  (cache_hit_i),
  .bus_ack_i    (bus_ack_i),
  .cyc_start_o  (cyc_start_o),
  .addr_strobe_o(addr_strobe_o),
  .fetch_done_o (fetch_done_o),
  .data_done_o  (data_done_o),
  .in_probe     (in_probe),
  .fetch_launch (fetch_launch)
);

// File: tb/sim_spec_fetch_bus.sv
module sim_spec_fetch_bus;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LANES = 4;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [GW-1:0] gap_cfg = '0;
  logic          fetch_req = 1'b0, cache_hit = 1'b0, data_req = 1'b0, data_we = 1'b0, bus_ack = 1'b0;
  logic [AW-1:0] fetch_addr = '0, data_addr = '0;
  logic [1:0]    data_size = '0;
  logic          cyc_start, addr_strobe, read_sig, fetch_done, data_done;
  logic [AW-1:0] addr;
  logic [LANES-1:0] byte_en;

  typedef struct packed {
    logic [AW-1:0]    addr;
    logic [LANES-1:0] be;
    logic             rd;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_fail = 0;
  logic strobe_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_fetch_bus #(.AW(AW), .LANES(LANES), .GW(GW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gap_cfg_i(gap_cfg),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr), .cache_hit_i(cache_hit),
    .data_req_i(data_req), .data_we_i(data_we), .data_size_i(data_size),
    .data_addr_i(data_addr), .bus_ack_i(bus_ack),
    .cyc_start_o(cyc_start), .addr_strobe_o(addr_strobe), .read_o(read_sig),
    .addr_o(addr), .byte_en_o(byte_en), .fetch_done_o(fetch_done), .data_done_o(data_done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: score each new bus cycle against the expected queue
  always @(negedge clk) begin
    #2;
    if (rst_n && addr_strobe && !strobe_seen) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4/R5 scoreboard addr", addr, e.addr);
        chk("R9 scoreboard byte_en", byte_en, e.be);
        chk("R5 scoreboard read", read_sig, e.rd);
      end
    end
    strobe_seen = addr_strobe;
  end

  task automatic data_xfer(logic [AW-1:0] a, logic [1:0] sz, logic we, logic [LANES-1:0] be);
    tick();
    data_req = 1; data_addr = a; data_size = sz; data_we = we;
    exp_q.push_back('{addr: a, be: be, rd: ~we});
    #1 chk("R5 start", cyc_start, 1);
    tick(); #1 chk("R5 strobe", addr_strobe, 1);
    chk("R7 no start in cycle", cyc_start, 0);
    tick(); bus_ack = 1; #1 chk("R5 done", data_done, 1);
    tick(); bus_ack = 0; data_req = 0; #1 chk("R5 release", addr_strobe, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) tick();
    #1;
    chk("R1 cyc_start", cyc_start, 0);
    chk("R1 strobe", addr_strobe, 0);
    chk("R1 done", {fetch_done, data_done}, 0);
    chk("R1 read", read_sig, 1);
    tick(); rst_n = 1;

    // R3: fetch hit, request held through probe
    tick(); fetch_req = 1; fetch_addr = 32'h100;
    #1 chk("R2 fetch start", cyc_start, 1);
    tick(); cache_hit = 1;
    #1 chk("R8 no back-to-back fetch", cyc_start, 0);
    tick(); cache_hit = 0; fetch_req = 0;
    #1 chk("R3 no strobe on hit", addr_strobe, 0);
    tick(); #1 chk("R3 idle after hit", addr_strobe, 0);

    // R4: fetch miss, unaligned address, one wait clock
    tick(); fetch_req = 1; fetch_addr = 32'h203;
    exp_q.push_back('{addr: 32'h203, be: 4'b1111, rd: 1'b1});
    #1 chk("R2 fetch start", cyc_start, 1);
    tick(); cache_hit = 0; #1 chk("R4 strobe not yet", addr_strobe, 0);
    tick(); #1 chk("R4 strobe", addr_strobe, 1);
    chk("R7 busy no start", cyc_start, 0);
    tick(); #1 chk("R4 strobe held", addr_strobe, 1);
    chk("R4 no early done", fetch_done, 0);
    tick(); bus_ack = 1; #1 chk("R4 fetch done", fetch_done, 1);
    chk("R4 not data done", data_done, 0);
    tick(); bus_ack = 0; fetch_req = 0; #1 chk("R4 strobe drop", addr_strobe, 0);

    // R9 lane patterns
    data_xfer(32'h1003, 2'b01, 1'b1, 4'b0001);
    data_xfer(32'h1000, 2'b00, 1'b0, 4'b1111);
    data_xfer(32'h1005, 2'b10, 1'b1, 4'b0110);
    data_xfer(32'h1007, 2'b10, 1'b0, 4'b0001);
    data_xfer(32'h1008, 2'b11, 1'b0, 4'b1110);
    data_xfer(32'h100a, 2'b00, 1'b1, 4'b0011);

    // R6: data wins over fetch
    tick(); fetch_req = 1; fetch_addr = 32'h300; data_req = 1; data_addr = 32'h2000;
    data_size = 2'b00; data_we = 0;
    exp_q.push_back('{addr: 32'h2000, be: 4'b1111, rd: 1'b1});
    #1 chk("R6 start", cyc_start, 1);
    tick(); #1 chk("R6 data first", addr_strobe, 1);
    chk("R7 fetch held off", cyc_start, 0);
    tick(); bus_ack = 1; #1 chk("R6 data done", data_done, 1);
    chk("R6 fetch not done", fetch_done, 0);
    tick(); bus_ack = 0; data_req = 0; #1 chk("R6 fetch after data", cyc_start, 1);
    tick(); cache_hit = 1; fetch_req = 0; #1 chk("R3 hit no start", cyc_start, 0);
    tick(); cache_hit = 0; #1 chk("R3 no strobe", addr_strobe, 0);

    // R8: data launch in the hit clock
    tick(); fetch_req = 1; fetch_addr = 32'h400; #1 chk("R2 fetch start", cyc_start, 1);
    tick(); fetch_req = 0; cache_hit = 1; data_req = 1; data_addr = 32'h3001;
    data_size = 2'b10; data_we = 1;
    exp_q.push_back('{addr: 32'h3001, be: 4'b0110, rd: 1'b0});
    #1 chk("R8 back-to-back start", cyc_start, 1);
    tick(); cache_hit = 0; #1 chk("R8 data strobe", addr_strobe, 1);
    chk("R5 write", read_sig, 0);
    tick(); bus_ack = 1; #1 chk("R5 done", data_done, 1);
    tick(); bus_ack = 0; data_req = 0; #1 chk("R5 release", addr_strobe, 0);

    // R10: gap of three clocks
    tick(); gap_cfg = 4'd3;
    tick(); data_req = 1; data_addr = 32'h4000; data_size = 2'b01; data_we = 0;
    exp_q.push_back('{addr: 32'h4000, be: 4'b1000, rd: 1'b1});
    #1 chk("R10 start after long idle", cyc_start, 1);
    tick(); #1 chk("R5 strobe", addr_strobe, 1);
    tick(); bus_ack = 1; #1 chk("R5 done", data_done, 1);
    tick(); bus_ack = 0; data_addr = 32'h4006; data_size = 2'b11; data_we = 1;
    exp_q.push_back('{addr: 32'h4006, be: 4'b0011, rd: 1'b0});
    #1 chk("R10 gap holds", cyc_start, 0);
    tick(); #1 chk("R10 gap met", cyc_start, 1);
    tick(); #1 chk("R5 strobe", addr_strobe, 1);
    tick(); bus_ack = 1; #1 chk("R5 done", data_done, 1);
    tick(); bus_ack = 0; data_req = 0; gap_cfg = '0;
    repeat (3) tick();
    #1 chk("R4 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule